// File: doc/BRIEF.md
# Serial Bit-Rate Generator

This block produces the bit timing for one serial channel. A free-running prescaler divides the system clock by a selectable power of four. An 8-bit reloadable counter then divides the prescaled enable by (rate + 1). A final tick counter, whose length depends on the operating mode, turns those ticks into a one-cycle bit strobe. In asynchronous mode it also produces a 16x oversampling strobe for the receive sampler. Clocked synchronous mode uses a short final division. Smart-card mode uses a long one, picked from four basic-period counts.

Software programs the block through a two-entry write/read port: a rate register and a control register. Every write restarts the whole chain, so the new timing takes effect from a known phase. Each channel instantiates its own copy, so channels run at independent rates. Deasserting `run` parks every counter at its start value and keeps both strobes low.

Top module: `serial_rate_gen`

## Requirements
- R1: After reset the rate register reads 0xFF and the control register reads 0x00 (asynchronous mode, clock select 0, card select 0), and both strobes are low.
- R2: Address 0 is the 8-bit rate register N, writable with any value 0..255. Address 1 is the control register: bits [1:0] clock select n, bits [3:2] mode (00 asynchronous, 01 clocked synchronous, 10 and 11 smart card), bits [5:4] card select. Bits [7:6] read as zero. Both registers read back at any time, combinationally from `cpu_addr`.
- R3: Clock select n divides the system clock by 4^n (1, 4, 16, 64) ahead of the rate divider, so one divider tick lasts 4^n × (N+1) system clocks.
- R4: In asynchronous mode the bit strobe period is 32 × 4^n × (N+1) system clocks.
- R5: In asynchronous mode the sample strobe period is 2 × 4^n × (N+1) system clocks, and every bit strobe coincides with a sample strobe (the 16th).
- R6: In clocked synchronous mode the bit strobe period is 4 × 4^n × (N+1) system clocks. Outside asynchronous mode the sample strobe stays low.
- R7: In smart-card mode the bit strobe period is 2 × S × 4^n × (N+1) system clocks, with card select 00, 01, 10, 11 giving S = 32, 64, 372, 256.
- R8: Each strobe is high for exactly one system clock. After a restart, the first bit strobe is high in the P-th cycle that follows the restarting clock edge, where P is the bit period.
- R9: Any register write, to either address and even with an unchanged value, restarts the prescaler, the divider and the tick counter at that clock edge.
- R10: While `run` is low both strobes are low and all counters return to their start values. Counting resumes from the start when `run` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Count enable; low parks the chain |
| cpu_we | input | 1 | Register write strobe |
| cpu_addr | input | 1 | Register select: 0 rate, 1 control |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data of the addressed register |
| bit_stb | output | 1 | One-cycle bit-period strobe |
| smp_stb | output | 1 | One-cycle 16x sample strobe (asynchronous mode only) |

## Verification
The hardest situation to reach from the ports is a restart that lands mid-period. This can be a write that leaves a register unchanged, or a `run` drop partway through a bit, after which the phase must restart exactly. The stimulus builds it by running a short period for part of a bit and then rewriting the same rate value. It also drops `run` for a few cycles inside a bit and changes the rate while counting. The behavioural model restarts its own cycle count on those same events and predicts every strobe cycle by cycle. The bench steers the long smart-card periods (744 and 1024 cycles) to small N and n so that complete bits fit in the run.

// File: rtl/brg_pkg.sv
package brg_pkg;

   localparam int CSEL_W = 2;
   localparam int SSEL_W = 2;

   typedef enum logic [1:0] {
      MODE_ASYNC    = 2'b00,
      MODE_SYNC     = 2'b01,
      MODE_CARD     = 2'b10,
      MODE_CARD_ALT = 2'b11
   } brg_mode_e;

   // Control register layout, MSB first: [5:4] card select, [3:2] mode, [1:0] clock select
   typedef struct packed {
      logic [SSEL_W-1:0] ssel;
      brg_mode_e         mode;
      logic [CSEL_W-1:0] csel;
   } brg_ctrl_t;

   localparam int CTRL_W = $bits(brg_ctrl_t);

endpackage

// File: rtl/brg_regs.sv
module brg_regs
   import brg_pkg::*;
#(
   parameter int RATE_W = 8,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_we,
   input  logic              cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic [RATE_W-1:0] rate,
   output brg_ctrl_t         ctrl,
   output logic              restart
);

   logic [RATE_W-1:0] rate_q;
   brg_ctrl_t         ctrl_q;
   logic [CTRL_W-1:0] ctrl_bits;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rate_q <= '1;
         ctrl_q <= '0;
      end else if (cpu_we) begin
         if (cpu_addr) ctrl_q <= brg_ctrl_t'(cpu_wdata[CTRL_W-1:0]);
         else          rate_q <= cpu_wdata[RATE_W-1:0];
      end
   end

   assign ctrl_bits = ctrl_q;
   assign cpu_rdata = cpu_addr ? DATA_W'(ctrl_bits) : DATA_W'(rate_q);
   assign rate      = rate_q;
   assign ctrl      = ctrl_q;
   // every accepted write re-phases the chain at the same edge
   assign restart   = cpu_we;

endmodule

// File: rtl/brg_prescaler.sv
module brg_prescaler
   import brg_pkg::*;
#(
   parameter int STEP_LOG2 = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              restart,
   input  logic [CSEL_W-1:0] csel,
   output logic              pre_en
);

   localparam int PRE_W = ((1 << CSEL_W) - 1) * STEP_LOG2;

   if (PRE_W == 0) begin : g_flat
      // every clock select divides by one
      assign pre_en = run;
   end else begin : g_count
      logic [PRE_W:0]   span;
      logic [PRE_W-1:0] lim;
      logic [PRE_W-1:0] pc;

      assign span = (PRE_W+1)'(1) << (int'(csel) * STEP_LOG2);
      assign lim  = PRE_W'(span - 1'b1);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                pc <= '0;
         else if (restart || !run)  pc <= '0;
         else if (pc == lim)        pc <= '0;
         else                       pc <= pc + 1'b1;
      end

      assign pre_en = run && (pc == lim);

      // R3
      pre_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
         pc <= lim);
   end

endmodule

// File: rtl/brg_divider.sv
module brg_divider #(
   parameter int RATE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              restart,
   input  logic              pre_en,
   input  logic [RATE_W-1:0] rate,
   output logic              tick
);

   logic [RATE_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               cnt <= '0;
      else if (restart || !run) cnt <= '0;
      else if (pre_en)          cnt <= (cnt == rate) ? '0 : cnt + 1'b1;
   end

   assign tick = pre_en && (cnt == rate);

   // R9
   div_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (cnt == '0));

   // R3
   div_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= rate);

endmodule

// File: rtl/brg_bitgen.sv
module brg_bitgen
   import brg_pkg::*;
#(
   parameter int SMP_TICKS   = 2,
   parameter int SMP_PER_BIT = 16,
   parameter int SYNC_TICKS  = 4,
   parameter int CARD_S0     = 32,
   parameter int CARD_S1     = 64,
   parameter int CARD_S2     = 372,
   parameter int CARD_S3     = 256
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              restart,
   input  logic              tick,
   input  brg_mode_e         mode,
   input  logic [SSEL_W-1:0] ssel,
   output logic              bit_stb,
   output logic              smp_stb
);

   localparam int ASYNC_TICKS = SMP_TICKS * SMP_PER_BIT;
   localparam int NSEL        = 1 << SSEL_W;
   localparam int CARD_S [4]  = '{CARD_S0, CARD_S1, CARD_S2, CARD_S3};

   function automatic int longest();
      int m;
      m = ASYNC_TICKS;
      if (SYNC_TICKS > m) m = SYNC_TICKS;
      for (int i = 0; i < 4; i++)
         if (2 * CARD_S[i] > m) m = 2 * CARD_S[i];
      return m;
   endfunction

   localparam int TC_MAX = longest();
   localparam int TC_W   = (TC_MAX > 1) ? $clog2(TC_MAX) : 1;
   localparam logic [TC_W-1:0] SMP_MASK = TC_W'(SMP_TICKS - 1);

   if (NSEL != 4) begin : g_bad_sel
      $error("card select must address exactly four entries");
   end

   logic [TC_W-1:0] card_last [4];
   logic [TC_W-1:0] last;
   logic [TC_W-1:0] tc;

   for (genvar gi = 0; gi < 4; gi++) begin : g_card
      // a card bit spans two divider ticks per basic period
      assign card_last[gi] = TC_W'(2 * CARD_S[gi] - 1);
   end

   always_comb begin
      case (mode)
         MODE_ASYNC: last = TC_W'(ASYNC_TICKS - 1);
         MODE_SYNC:  last = TC_W'(SYNC_TICKS - 1);
         default:    last = card_last[ssel];
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               tc <= '0;
      else if (restart || !run) tc <= '0;
      else if (tick)            tc <= (tc == last) ? '0 : tc + 1'b1;
   end

   assign bit_stb = tick && (tc == last);
   assign smp_stb = (mode == MODE_ASYNC) && tick && ((tc & SMP_MASK) == SMP_MASK);

   // R8
   bit_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bit_stb |=> !bit_stb);

   // R7
   tc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tc <= last);

   // R10
   idle_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (tc == '0));

endmodule

// File: rtl/serial_rate_gen.sv
module serial_rate_gen
   import brg_pkg::*;
#(
   parameter int RATE_W      = 8,
   parameter int DATA_W      = 8,
   parameter int STEP_LOG2   = 2,
   parameter int SMP_TICKS   = 2,
   parameter int SMP_PER_BIT = 16,
   parameter int SYNC_TICKS  = 4,
   parameter int CARD_S0     = 32,
   parameter int CARD_S1     = 64,
   parameter int CARD_S2     = 372,
   parameter int CARD_S3     = 256
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              cpu_we,
   input  logic              cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              bit_stb,
   output logic              smp_stb
);

   if (RATE_W < 1 || RATE_W > DATA_W) begin : g_bad_rate
      $error("RATE_W must lie in 1..DATA_W");
   end
   if (DATA_W <= CTRL_W) begin : g_bad_data
      $error("DATA_W must exceed the control field width");
   end
   if (STEP_LOG2 < 0) begin : g_bad_step
      $error("STEP_LOG2 must not be negative");
   end
   if (SMP_TICKS < 1 || (SMP_TICKS & (SMP_TICKS - 1)) != 0) begin : g_bad_smp
      $error("SMP_TICKS must be a power of two");
   end
   if (SYNC_TICKS < 2 || SMP_PER_BIT < 2) begin : g_bad_len
      $error("final divisions must be at least two ticks");
   end

   logic [RATE_W-1:0] rate;
   brg_ctrl_t         ctrl;
   logic              restart;
   logic              pre_en;
   logic              tick;

   brg_regs #(
      .RATE_W (RATE_W),
      .DATA_W (DATA_W)
   ) i_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .cpu_we    (cpu_we),
      .cpu_addr  (cpu_addr),
      .cpu_wdata (cpu_wdata),
      .cpu_rdata (cpu_rdata),
      .rate      (rate),
      .ctrl      (ctrl),
      .restart   (restart)
   );

   brg_prescaler #(
      .STEP_LOG2 (STEP_LOG2)
   ) i_pre (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run),
      .restart (restart),
      .csel    (ctrl.csel),
      .pre_en  (pre_en)
   );

   brg_divider #(
      .RATE_W (RATE_W)
   ) i_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run),
      .restart (restart),
      .pre_en  (pre_en),
      .rate    (rate),
      .tick    (tick)
   );

   brg_bitgen #(
      .SMP_TICKS   (SMP_TICKS),
      .SMP_PER_BIT (SMP_PER_BIT),
      .SYNC_TICKS  (SYNC_TICKS),
      .CARD_S0     (CARD_S0),
      .CARD_S1     (CARD_S1),
      .CARD_S2     (CARD_S2),
      .CARD_S3     (CARD_S3)
   ) i_bit (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run),
      .restart (restart),
      .tick    (tick),
      .mode    (ctrl.mode),
      .ssel    (ctrl.ssel),
      .bit_stb (bit_stb),
      .smp_stb (smp_stb)
   );

   // R5
   smp_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_stb && ctrl.mode == MODE_ASYNC) |-> smp_stb);

   // R8
   smp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      smp_stb |=> !smp_stb);

endmodule

// File: tb/test_serial_rate_gen.sv
module test_serial_rate_gen;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       run = 1'b0;
   logic       cpu_we = 1'b0;
   logic       cpu_addr = 1'b0;
   logic [7:0] cpu_wdata = 8'h00;
   logic [7:0] cpu_rdata;
   logic       bit_stb;
   logic       smp_stb;

   always #5 clk = ~clk;

   serial_rate_gen i_serial_rate_gen (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (run),
      .cpu_we    (cpu_we),
      .cpu_addr  (cpu_addr),
      .cpu_wdata (cpu_wdata),
      .cpu_rdata (cpu_rdata),
      .bit_stb   (bit_stb),
      .smp_stb   (smp_stb)
   );

   int    n_cmp = 0;
   int    n_bad = 0;
   bit    done  = 1'b0;

   // behavioural model state
   int    m_rate, m_csel, m_mode, m_ssel, k;
   string cause;
   int    p_bit, p_smp, e_bit, e_smp, e_rd;
   string tag_bit, tag_smp;

   function automatic int card_s(int s);
      case (s)
         0:       return 32;
         1:       return 64;
         2:       return 372;
         default: return 256;
      endcase
   endfunction

   function automatic int tick_len();
      return (m_rate + 1) * (1 << (2 * m_csel));
   endfunction

   function automatic int bit_len();
      if (m_mode == 0)      return 32 * tick_len();
      else if (m_mode == 1) return 4 * tick_len();
      else                  return 2 * card_s(m_ssel) * tick_len();
   endfunction

   task automatic chk(string tag, int act, int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_rate = 255; m_csel = 0; m_mode = 0; m_ssel = 0; k = 0; cause = "R1";
      end else if (cpu_we) begin
         if (cpu_addr) begin
            m_csel = int'(cpu_wdata[1:0]);
            m_mode = int'(cpu_wdata[3:2]);
            m_ssel = int'(cpu_wdata[5:4]);
         end else begin
            m_rate = int'(cpu_wdata);
         end
         k = 0; cause = "R9";
      end else if (!run) begin
         k = 0; cause = "R10";
      end else begin
         k++;
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         p_bit = bit_len();
         p_smp = 2 * tick_len();
         e_bit = (run && ((k + 1) % p_bit == 0)) ? 1 : 0;
         e_smp = (run && m_mode == 0 && ((k + 1) % p_smp == 0)) ? 1 : 0;
         e_rd  = cpu_addr ? (m_ssel * 16 + m_mode * 4 + m_csel) : m_rate;
         tag_bit = (m_mode == 0) ? "R4" : ((m_mode == 1) ? "R6" : "R7");
         if (m_csel != 0) tag_bit = {tag_bit, "/R3"};
         tag_bit = {tag_bit, "/R8/", cause, " bit_stb"};
         tag_smp = (m_mode == 0) ? "R5 smp_stb" : "R6 smp_stb";
         chk(tag_bit, int'(bit_stb), e_bit);
         chk(tag_smp, int'(smp_stb), e_smp);
         chk("R2 cpu_rdata", int'(cpu_rdata), e_rd);
      end
   end

   task automatic wr(bit a, logic [7:0] d);
      @(posedge clk); #1;
      cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
      @(posedge clk); #1;
      cpu_we = 1'b0;
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk); #1;
         cpu_addr = ~cpu_addr;
      end
   endtask

   task automatic set_run(bit v);
      @(posedge clk); #1;
      run = v;
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      #(150000 * 10);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         finish_run();
      end
   end

   initial begin
      // R1 reset state, checked while reset is held
      repeat (2) @(negedge clk);
      cpu_addr = 1'b0; #1;
      chk("R1 rate reset", int'(cpu_rdata), 255);
      cpu_addr = 1'b1; #1;
      chk("R1 ctrl reset", int'(cpu_rdata), 0);
      chk("R1 bit_stb reset", int'(bit_stb), 0);
      chk("R1 smp_stb reset", int'(smp_stb), 0);
      @(posedge clk); #1;
      rst_n = 1'b1; cpu_addr = 1'b0;
      idle(5);
      // default rate 255, async n=0: period 8192
      set_run(1'b1);
      idle(8300);
      // R4 async N=0 n=0 (32), N=2 n=1 (384), N=0 n=3 (2048)
      wr(1'b0, 8'd0); wr(1'b1, 8'h00); idle(200);
      wr(1'b0, 8'd2); wr(1'b1, 8'h01); idle(1000);
      wr(1'b0, 8'd0); wr(1'b1, 8'h03); idle(4200);
      // R6 sync N=0 n=0 (4), N=4 n=2 (320)
      wr(1'b1, 8'h04); idle(50);
      wr(1'b0, 8'd4); wr(1'b1, 8'h06); idle(700);
      // R7 card, N=0 n=0, each card select: 64, 128, 744, 512
      wr(1'b0, 8'd0);
      wr(1'b1, 8'h08); idle(200);
      wr(1'b1, 8'h18); idle(300);
      wr(1'b1, 8'h28); idle(1500);
      wr(1'b1, 8'h38); idle(1100);
      // R7 mode 11 also card, select 11 (512)
      wr(1'b1, 8'h3C); idle(1100);
      // R7 card S=64 N=1 n=1 (1024)
      wr(1'b0, 8'd1); wr(1'b1, 8'h19); idle(2100);
      // R9 mid-period restarts: async N=1 n=0 (64)
      wr(1'b1, 8'h00); idle(40);
      wr(1'b0, 8'd1); idle(50);
      wr(1'b1, 8'h00); idle(30);
      wr(1'b0, 8'd3); idle(300);
      // R10 run dropped inside a bit
      wr(1'b0, 8'd0); idle(20);
      set_run(1'b0); idle(10);
      set_run(1'b1); idle(25);
      set_run(1'b0); idle(5);
      set_run(1'b1); idle(100);
      // R2 upper control bits read as zero
      wr(1'b1, 8'hFF); idle(60);
      wr(1'b1, 8'h04); idle(40);
      set_run(1'b0); idle(10);
      finish_run();
   end

endmodule